// File: doc/BRIEF.md
# March C- Memory Self-Test Sequencer

This block is a hardware sequencer that runs the irredundant six-element March C- test on a bit-wide synchronous RAM of `DEPTH` words. It drives the address, write strobe, write data and read strobe of the memory under test. It also checks every read result against the value the algorithm predicts. The test is launched by a start pulse. It ends with a one-cycle completion pulse and a sticky pass/fail flag. Along with the flag, the block records the address, element number and operation number of the first read that disagreed.

Elements run back to back, with one memory operation per clock cycle. Within an element, every operation of the element is applied to one address before the address moves on. The address moves up from 0 or down from `DEPTH-1`, depending on the element. An extended mode adds a read-back of 1 to the second element, so that stuck-open cells are caught. Read data is expected one cycle after the read strobe. The comparison travels down a small pipeline beside the operation stream, so the sequencer never stalls.

Top module: `mbist_march_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `fail_o`, `mem_we_o` and `mem_re_o` are all 0.
- R2: A start pulse sampled while idle begins the test. The first operation (write 0 at address 0) is driven in the very next cycle, and one operation is issued every cycle until the last one.
- R3: In normal mode the elements are numbered 0 to 5 and run in this order. Element 0 is up, w0. Element 1 is up, r0 then w1. Element 2 is up, r1 then w0. Element 3 is down, r0 then w1. Element 4 is down, r1 then w0. Element 5 is up, r0. The whole test issues exactly 10·DEPTH operations.
- R4: With `ext_mode_i` high when start is sampled, element 1 becomes r0, w1, r1 (operation index 2 is the extra read), and the test issues exactly 11·DEPTH operations.
- R5: An up element visits addresses 0 to DEPTH-1 and a down element visits DEPTH-1 to 0, one address step at a time. All operations of the element are applied to one address before the address changes.
- R6: The result of a read issued in cycle t is taken from `mem_rdata_i` in cycle t+1 and compared with the value the read expects.
- R7: The first mismatch sets `fail_o`. It also captures the address (`fail_addr_o`), the element number 0 to 5 (`fail_elem_o`) and the operation index within the element, counted from 0 (`fail_op_o`). Later mismatches change none of these, and the test runs on to its end.
- R8: `done_o` is high for exactly one cycle, two cycles after the cycle of the last operation, and the block is then idle. `fail_o` and the captured fields keep their values until the next start.
- R9: A start pulse while a test is running has no effect on the operation stream or on its timing.
- R10: An accepted start clears `fail_o` and the captured fields.
- R11: Write and read strobes are never high together. During a write, `mem_wdata_o` carries the value the operation writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| ext_mode_i | input | 1 | Selects the extended sequence, sampled at start |
| mem_addr_o | output | AW | Address to the memory under test |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 1 | Write data bit |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | 1 | Read data, valid one cycle after `mem_re_o` |
| busy_o | output | 1 | Test in progress, including the final compare cycle |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | AW | Address of the first mismatch |
| fail_elem_o | output | 3 | Element number of the first mismatch |
| fail_op_o | output | 2 | Operation index of the first mismatch |

## Verification
The bench goes after the element turnovers and both ends of the address range. Cells stuck at 1 and at 0 are placed at address 0, in the middle and at `DEPTH-1`. A design that compared the read data in the wrong cycle, reversed a descending element or dropped the extra read of extended mode would report the wrong first-failure element, operation or address, or none at all. A cell stuck at 0 keeps failing long after its first mismatch, so a capture that was overwritten would show a later element. A start pulse during a run and a clean run after a failing one expose a sequencer that restarts on a busy start, or a fail flag that is never cleared.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int unsigned NUM_ELEM = 6;
  localparam int unsigned ELEM_W   = 3;
  localparam int unsigned OPI_W    = 2;
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic wr;   // 1: write, 0: read
    logic val;  // value written, or value expected on read
  } march_op_t;

  // Elements 3 and 4 walk the address space downward.
  function automatic logic elem_is_down(input logic [ELEM_W-1:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  // Number of operations per address for an element.
  function automatic logic [OPI_W-1:0] elem_len(input logic [ELEM_W-1:0] e,
                                                input logic ext);
    case (e)
      3'd0, 3'd5: return 2'd1;
      3'd1:       return ext ? 2'd3 : 2'd2;
      default:    return 2'd2;
    endcase
  endfunction

  // Operation i of element e.
  function automatic march_op_t elem_op(input logic [ELEM_W-1:0] e,
                                        input logic [OPI_W-1:0]  i);
    march_op_t o;
    o.wr  = 1'b0;
    o.val = 1'b0;
    case (e)
      3'd0: o.wr = 1'b1;
      3'd5: o.wr = 1'b0;
      default: begin
        case (i)
          2'd0: begin o.wr = 1'b0; o.val = ~e[0]; end
          2'd1: begin o.wr = 1'b1; o.val =  e[0]; end
          default: begin o.wr = 1'b0; o.val = 1'b1; end
        endcase
      end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          load_down_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_i)  addr_q <= load_down_i ? TOP_ADDR : '0;
    else if (step_i)  addr_q <= down_i ? addr_q - AW'(1) : addr_q + AW'(1);
  end

  assign addr_o   = addr_q;
  assign at_end_o = down_i ? (addr_q == '0) : (addr_q == TOP_ADDR);

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_i,
  input  logic              at_end_i,
  output seq_state_e        state_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic [OPI_W-1:0]  opi_o,
  output march_op_t         op_o,
  output logic              issue_o,
  output logic              start_acc_o,
  output logic              addr_load_o,
  output logic              addr_load_down_o,
  output logic              addr_step_o
);

  seq_state_e        st_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OPI_W-1:0]  opi_q;
  logic              ext_q;

  logic              last_op;
  logic [ELEM_W-1:0] nxt_elem;

  assign start_acc_o = (st_q == ST_IDLE) && start_i;
  assign issue_o     = (st_q == ST_RUN);
  assign last_op     = (opi_q == (elem_len(elem_q, ext_q) - 2'd1));
  assign nxt_elem    = elem_q + ELEM_W'(1);

  always_comb begin
    addr_load_o      = 1'b0;
    addr_load_down_o = 1'b0;
    addr_step_o      = 1'b0;
    if (start_acc_o) begin
      addr_load_o = 1'b1;
    end else if (issue_o && last_op) begin
      if (at_end_i) begin
        if (elem_q != LAST_ELEM) begin
          addr_load_o      = 1'b1;
          addr_load_down_o = elem_is_down(nxt_elem);
        end
      end else begin
        addr_step_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      elem_q <= '0;
      opi_q  <= '0;
      ext_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            elem_q <= '0;
            opi_q  <= '0;
            ext_q  <= ext_i;
          end
        end
        ST_RUN: begin
          if (last_op) begin
            opi_q <= '0;
            if (at_end_i) begin
              if (elem_q == LAST_ELEM) st_q   <= ST_DRAIN;
              else                     elem_q <= nxt_elem;
            end
          end else begin
            opi_q <= opi_q + OPI_W'(1);
          end
        end
        ST_DRAIN: st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign elem_o  = elem_q;
  assign opi_o   = opi_q;
  assign op_o    = elem_op(elem_q, opi_q);

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rd_issue_i,
  input  logic              exp_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [OPI_W-1:0]  opi_i,
  input  logic              rdata_i,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [OPI_W-1:0]  fail_opi_o
);

  // Stage 1: context of the read in flight
  logic              pend_q;
  logic              exp_q;
  logic [AW-1:0]     addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OPI_W-1:0]  opi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
      elem_q <= '0;
      opi_q  <= '0;
    end else begin
      pend_q <= rd_issue_i;
      if (rd_issue_i) begin
        exp_q  <= exp_i;
        addr_q <= addr_i;
        elem_q <= elem_i;
        opi_q  <= opi_i;
      end
    end
  end

  assign mismatch_o = pend_q && (rdata_i != exp_q);

  // Stage 2: first-failure capture
  logic              fail_q;
  logic [AW-1:0]     faddr_q;
  logic [ELEM_W-1:0] felem_q;
  logic [OPI_W-1:0]  fopi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
      fopi_q  <= '0;
    end else if (clear_i) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
      fopi_q  <= '0;
    end else if (mismatch_o && !fail_q) begin
      fail_q  <= 1'b1;
      faddr_q <= addr_q;
      felem_q <= elem_q;
      fopi_q  <= opi_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = faddr_q;
  assign fail_elem_o = felem_q;
  assign fail_opi_o  = fopi_q;

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ext_mode_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_wdata_o,
  output logic          mem_re_o,
  input  logic          mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [2:0]    fail_elem_o,
  output logic [1:0]    fail_op_o
);

  // Named internal events, also observed by the bound checker
  seq_state_e        seq_state;
  logic [ELEM_W-1:0] cur_elem;
  logic [OPI_W-1:0]  cur_op;
  march_op_t         cur_cmd;
  logic              issue;
  logic              start_acc;
  logic              addr_load;
  logic              addr_load_down;
  logic              addr_step;
  logic              addr_at_end;
  logic              cmp_mismatch;
  logic [AW-1:0]     addr;

  mbist_seq u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .ext_i            (ext_mode_i),
    .at_end_i         (addr_at_end),
    .state_o          (seq_state),
    .elem_o           (cur_elem),
    .opi_o            (cur_op),
    .op_o             (cur_cmd),
    .issue_o          (issue),
    .start_acc_o      (start_acc),
    .addr_load_o      (addr_load),
    .addr_load_down_o (addr_load_down),
    .addr_step_o      (addr_step)
  );

  mbist_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (addr_load),
    .load_down_i (addr_load_down),
    .step_i      (addr_step),
    .down_i      (elem_is_down(cur_elem)),
    .addr_o      (addr),
    .at_end_o    (addr_at_end)
  );

  mbist_cmp #(.DEPTH(DEPTH)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (start_acc),
    .rd_issue_i  (mem_re_o),
    .exp_i       (cur_cmd.val),
    .addr_i      (addr),
    .elem_i      (cur_elem),
    .opi_i       (cur_op),
    .rdata_i     (mem_rdata_i),
    .mismatch_o  (cmp_mismatch),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_elem_o (fail_elem_o),
    .fail_opi_o  (fail_op_o)
  );

  assign mem_addr_o  = addr;
  assign mem_we_o    = issue &&  cur_cmd.wr;
  assign mem_re_o    = issue && !cur_cmd.wr;
  assign mem_wdata_o = issue &&  cur_cmd.val;
  assign busy_o      = (seq_state == ST_RUN) || (seq_state == ST_DRAIN);
  assign done_o      = (seq_state == ST_DONE);

endmodule

// File: rtl/mbist_march_ctrl_chk.sv
module mbist_march_ctrl_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_acc,
  input logic          issue,
  input logic [2:0]    cur_elem,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [2:0]    fail_elem_o,
  input logic [1:0]    fail_op_o
);

  a_r11_no_dual_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  a_r2_access_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> busy_o);

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_acc) |=> fail_o);

  a_r7_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_acc) |=>
      ($stable(fail_addr_o) && $stable(fail_elem_o) && $stable(fail_op_o)));

  a_r10_start_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !fail_o);

  a_r5_unit_address_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && $past(issue) && (cur_elem == $past(cur_elem)) &&
     (mem_addr_o != $past(mem_addr_o)))
    |-> (mem_addr_o == (mbist_pkg::elem_is_down(cur_elem) ?
                        $past(mem_addr_o) - AW'(1) : $past(mem_addr_o) + AW'(1))));

endmodule

bind mbist_march_ctrl mbist_march_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_acc   (start_acc),
  .issue       (issue),
  .cur_elem    (cur_elem),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .fail_elem_o (fail_elem_o),
  .fail_op_o   (fail_op_o)
);

// File: tb/mbist_march_ctrl_bench.sv
module mbist_march_ctrl_bench;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ext = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_wdata, mem_re;
  logic          rdata = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;
  logic [1:0]    fail_op;

  always #2 clk = ~clk;  // 250 MHz

  mbist_march_ctrl #(.DEPTH(DEPTH)) u_mbist_march_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .ext_mode_i  (ext),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_re_o    (mem_re),
    .mem_rdata_i (rdata),
    .busy_o      (busy),
    .done_o      (done),
    .fail_o      (fail),
    .fail_addr_o (fail_addr),
    .fail_elem_o (fail_elem),
    .fail_op_o   (fail_op)
  );

  // Memory under test: one-cycle read latency, optional stuck-at cell
  logic          mem [DEPTH];
  logic          flt_en = 1'b0;
  logic          flt_val = 1'b0;
  logic [AW-1:0] flt_addr = '0;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) rdata <= (flt_en && mem_addr == flt_addr) ? flt_val : mem[mem_addr];
  end

  // Scoreboard
  typedef struct packed {
    logic          wr;
    logic          val;
    logic [AW-1:0] addr;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, fails = 0;
  int cyc = 0;
  int first_op_cyc = -1;
  int op_seen = 0;
  int done_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver side: expected accesses for one element
  task automatic push_elem(input bit down, input int n,
                           input bit [2:0] wr, input bit [2:0] val);
    for (int k = 0; k < DEPTH; k++) begin
      int a;
      a = down ? DEPTH - 1 - k : k;
      for (int i = 0; i < n; i++) begin
        exp_t e;
        e.wr = wr[i]; e.val = val[i]; e.addr = AW'(a);
        sb_q.push_back(e);
      end
    end
  endtask

  task automatic build_expected(input bit ext_m);
    sb_q.delete();
    push_elem(1'b0, 1, 3'b001, 3'b000);                 // up   w0
    if (ext_m) push_elem(1'b0, 3, 3'b010, 3'b110);      // up   r0 w1 r1 (R4)
    else       push_elem(1'b0, 2, 3'b010, 3'b010);      // up   r0 w1    (R3)
    push_elem(1'b0, 2, 3'b010, 3'b001);                 // up   r1 w0
    push_elem(1'b1, 2, 3'b010, 3'b010);                 // down r0 w1
    push_elem(1'b1, 2, 3'b010, 3'b001);                 // down r1 w0
    push_elem(1'b0, 1, 3'b000, 3'b000);                 // up   r0
  endtask

  // Monitor: pops one expected access for every access the design makes
  always @(negedge clk) begin
    exp_t e;
    if (done) done_cnt++;
    if (mem_we || mem_re) begin
      op_seen++;
      if (first_op_cyc < 0) first_op_cyc = cyc;
      if (sb_q.size() == 0) begin
        check(1'b0, "R3", "access beyond expected stream", op_seen, 0);
      end else begin
        e = sb_q.pop_front();
        check(mem_addr == e.addr, "R5", "access address", int'(mem_addr), int'(e.addr));
        check(mem_we == e.wr && mem_re == !e.wr && (!e.wr || mem_wdata == e.val),
              "R11", "access kind/data {we,re,wdata}",
              int'({mem_we, mem_re, mem_wdata}), int'({e.wr, !e.wr, e.val}));
      end
    end
  end

  task automatic run_test(input bit ext_m, input int restart_at, input bit exp_fail,
                          input int ea, input int ee, input int eo, input string req);
    int exp_ops, k, done_at;
    build_expected(ext_m);
    exp_ops = sb_q.size();
    op_seen = 0; first_op_cyc = -1; done_cnt = 0;
    @(negedge clk); start = 1'b1; ext = ext_m;
    @(negedge clk); start = 1'b0;
    check(mem_we && mem_addr == '0, "R2", "first op is w0 at addr 0 next cycle",
          int'({mem_we, mem_addr}), int'({1'b1, {AW{1'b0}}}));
    check(fail == 1'b0, "R10", "fail cleared by start", int'(fail), 0);
    k = 0;
    while (!done && k < 4000) begin
      @(negedge clk);
      k++;
      start = (k == restart_at);
    end
    start = 1'b0;
    done_at = cyc;
    check(k < 4000, req, "done reached", k, 0);
    check(op_seen == exp_ops, ext_m ? "R4" : "R3", "operation count", op_seen, exp_ops);
    check(sb_q.size() == 0, "R3", "expected stream consumed", sb_q.size(), 0);
    check(done_at - first_op_cyc == exp_ops + 1, restart_at > 0 ? "R9" : "R8",
          "done cycle after first op", done_at - first_op_cyc, exp_ops + 1);
    check(fail == exp_fail, "R7", "fail flag", int'(fail), int'(exp_fail));
    if (exp_fail) begin
      check(int'(fail_addr) == ea, req, "first fail address", int'(fail_addr), ea);
      check(int'(fail_elem) == ee, req, "first fail element", int'(fail_elem), ee);
      check(int'(fail_op) == eo, req, "first fail op index", int'(fail_op), eo);
    end
    @(negedge clk);
    check(!done && !busy, "R8", "done one cycle then idle", int'({done, busy}), 0);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
    check(fail == exp_fail, "R8", "fail held after done", int'(fail), int'(exp_fail));
    if (exp_fail)
      check(int'(fail_addr) == ea, "R8", "capture held after done", int'(fail_addr), ea);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, fail, mem_we, mem_re} == 5'b0, "R1", "outputs in reset",
          int'({busy, done, fail, mem_we, mem_re}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, fail, mem_we, mem_re} == 5'b0, "R1", "outputs after reset",
          int'({busy, done, fail, mem_we, mem_re}), 0);

    // Clean runs, both modes
    run_test(1'b0, 0, 1'b0, 0, 0, 0, "R3");
    run_test(1'b1, 0, 1'b0, 0, 0, 0, "R4");

    // Stuck-at-1 in the middle: first r0 of element 1
    flt_en = 1'b1; flt_val = 1'b1; flt_addr = AW'(5);
    run_test(1'b0, 0, 1'b1, 5, 1, 0, "R7");

    // Stuck-at-0 at address 0: first r1 is element 2, op 0 (R6 timing)
    flt_val = 1'b0; flt_addr = '0;
    run_test(1'b0, 0, 1'b1, 0, 2, 0, "R6");

    // Stuck-at-0 at top address, extended: caught by the extra read
    flt_addr = AW'(DEPTH - 1);
    run_test(1'b1, 0, 1'b1, DEPTH - 1, 1, 2, "R4");

    // Clean run after failures, with a start pulse mid-run
    flt_en = 1'b0;
    run_test(1'b0, 40, 1'b0, 0, 0, 0, "R9");
    check(fail == 1'b0, "R10", "clean run after failing one", int'(fail), 0);

    finish_run();
  end

endmodule